// File: doc/BRIEF.md
# Interrupt Status Tabling Engine

This block records channel interrupt events into a table in storage, with no help from a processor. Each event is either an external interrupt raised by a remote device or a monitor completion, which happens when a transfer issued with monitor reaches its terminal count. For every event the engine writes a status word to the table, and for external events it also writes the device's access control word. It then advances its table pointer. The table position comes from a 36-bit active pointer word. Its upper 18 bits are a remaining word count and its lower 18 bits are a relative address. The relative address is added to a chain base value placed at bit 9 and above, which gives a 24-bit storage address.

Software loads two pointers: the active pointer and a spare, auxiliary pointer. When the active count runs out, the engine copies the auxiliary pointer into the active one and raises a vectored table-full interrupt. The hardware never alters the auxiliary pointer, so software can either let tabling wrap into the same area again or reload the auxiliary pointer to chain tables together. Software is told about tabling in one of two ways, picked by a mode input: a one-cycle pulse per entry, or a sticky flag that software polls and clears. One further event can wait in a pending slot while an entry is being written. Any event beyond that is refused.

Top module: `irq_table_engine`

## Requirements
- R1: When the engine is idle and has nothing pending, an event presented with `trig_valid` is accepted. The first storage write request (`mem_req`) is raised in the next cycle.
- R2: The first word of an entry is written at address `chain_base*512 + active_ptr[17:0]` (24 bits). The second word, when there is one, is written at that address plus 1.
- R3: First entry word layout: bit 35 = 1 for an external event and 0 for a monitor event. Bits 34-18 = `trig_status` for an external event and zero for a monitor event. Bits 17-14 = 0. Bits 13-0 = `trig_index`.
- R4: An external event (`trig_ext`=1) writes a second word equal to `trig_acw`. A monitor event (`trig_ext`=0) writes only the first word.
- R5: After each entry, the active pointer count (bits 35-18) goes down by 2 and its address (bits 17-0) goes up by 2, whether the entry had one word or two.
- R6: When an entry brings the active count to zero, the auxiliary pointer is copied into the active pointer. `full_irq` then pulses for one cycle, in the cycle after the last write of that entry, with `full_vec` = 150 (octal 226) + `bank_sel`.
- R7: The hardware never changes the auxiliary pointer. Every swap loads the same auxiliary contents until software reloads it.
- R8: With `act_immediate`=1, each finished entry gives a one-cycle `act_pulse` and leaves `act_flag` unchanged. With `act_immediate`=0, each finished entry sets the sticky `act_flag` and gives no pulse.
- R9: `act_clear` clears `act_flag`. A clear in the same cycle as a set wins.
- R10: An event that arrives while an entry is in progress is held in a one-deep pending slot and tabled after the current entry. While the slot is full, `trig_busy` is high and any event presented is dropped.
- R11: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_addr` and `mem_wdata` hold their values into the next cycle.
- R12: After reset: `mem_req`, `trig_busy`, `full_irq`, `act_pulse` and `act_flag` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_act | input | 1 | Load the active pointer from `ptr_wdata` |
| load_aux | input | 1 | Load the auxiliary pointer from `ptr_wdata` |
| ptr_wdata | input | 36 | Pointer word: count in bits 35-18, relative address in bits 17-0 |
| chain_base | input | 15 | Chain base, added at bit 9 and above |
| bank_sel | input | 9 | Bank select value added to the table-full vector |
| trig_valid | input | 1 | An event is presented this cycle |
| trig_ext | input | 1 | 1 = external event, 0 = monitor completion |
| trig_status | input | 17 | External status |
| trig_index | input | 14 | Device index |
| trig_acw | input | 36 | Device access control word |
| trig_busy | output | 1 | Pending slot full; events presented now are dropped |
| mem_req | output | 1 | Storage write request |
| mem_addr | output | 24 | Storage write address |
| mem_wdata | output | 36 | Storage write data |
| mem_ack | input | 1 | Write accepted in this cycle |
| full_irq | output | 1 | One-cycle table-full interrupt |
| full_vec | output | 10 | Table-full interrupt vector |
| act_immediate | input | 1 | 1 = activity pulse, 0 = sticky activity flag |
| act_pulse | output | 1 | One-cycle activity pulse |
| act_flag | output | 1 | Sticky activity flag |
| act_clear | input | 1 | Clear the sticky activity flag |

## Verification
The first write request appears in the cycle after an idle engine accepts an event. Each later word appears in the cycle after the previous word's acknowledge. `full_irq` and `act_pulse` are due in the cycle right after the acknowledge of an entry's last word, and `act_flag` changes at that same edge. The bench records every acknowledged write, interrupt and pulse at the clock edge, together with a cycle stamp. It then compares the recorded cycle numbers, so the table-full pulse is checked to arrive exactly one cycle after the last write. The bench drives inputs and samples `trig_busy` on the falling edge, and it also runs with stretched acknowledges to confirm that a waiting request holds still.

// File: rtl/tabling_pkg.sv
package tabling_pkg;
  localparam int WORD_W    = 36;
  localparam int REL_W     = 18;
  localparam int CNT_W     = WORD_W - REL_W;
  localparam int CBR_W     = 15;
  localparam int CBR_SHIFT = 9;
  localparam int ADDR_W    = CBR_W + CBR_SHIFT;
  localparam int BANK_W    = 9;
  localparam int VEC_W     = BANK_W + 1;
  localparam int IDX_W     = 14;
  localparam int STAT_W    = 17;
  localparam int GAP_W     = WORD_W - 1 - STAT_W - IDX_W;

  typedef struct packed {
    logic              ext;
    logic [STAT_W-1:0] status;
    logic [IDX_W-1:0]  index;
    logic [WORD_W-1:0] acw;
  } evt_t;

  function automatic logic [ADDR_W-1:0] entry_base(input logic [CBR_W-1:0] cbr,
                                                   input logic [WORD_W-1:0] ptr);
    return {cbr, {CBR_SHIFT{1'b0}}} + ADDR_W'(ptr[REL_W-1:0]);
  endfunction

  function automatic logic [WORD_W-1:0] head_word(input evt_t e);
    return {e.ext, (e.ext ? e.status : {STAT_W{1'b0}}), {GAP_W{1'b0}}, e.index};
  endfunction

  function automatic logic [WORD_W-1:0] ptr_step(input logic [WORD_W-1:0] ptr);
    return {ptr[WORD_W-1:REL_W] - CNT_W'(2), ptr[REL_W-1:0] + REL_W'(2)};
  endfunction

  function automatic logic [VEC_W-1:0] full_vector(input int base,
                                                   input logic [BANK_W-1:0] bank);
    return VEC_W'(base) + VEC_W'(bank);
  endfunction
endpackage

// File: rtl/tab_ptr_regs.sv
module tab_ptr_regs
  import tabling_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_act,
  input  logic              load_aux,
  input  logic [WORD_W-1:0] wdata,
  input  logic              adv,
  output logic [WORD_W-1:0] act_ptr,
  output logic              swap
);
  logic [WORD_W-1:0] aux_ptr;
  logic [WORD_W-1:0] stepped;

  always_comb begin
    stepped = ptr_step(act_ptr);
    swap    = adv && (stepped[WORD_W-1:REL_W] == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_ptr <= '0;
      aux_ptr <= '0;
    end else begin
      if (load_aux) aux_ptr <= wdata;
      if (load_act)  act_ptr <= wdata;
      else if (swap) act_ptr <= aux_ptr;
      else if (adv)  act_ptr <= stepped;
    end
  end

  // R7: only a software load may change the auxiliary pointer
  p_aux_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !load_aux |=> $stable(aux_ptr));
  // R6: an exhausting entry installs the auxiliary pointer
  p_swap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (swap && !load_act) |=> act_ptr == $past(aux_ptr));
  // R5: the address field moves up by two per entry
  p_adv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !swap && !load_act) |=> act_ptr[REL_W-1:0] == $past(act_ptr[REL_W-1:0]) + REL_W'(2));
endmodule

// File: rtl/tab_activity.sv
module tab_activity (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic immediate,
  input  logic clear,
  output logic pulse,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse <= 1'b0;
      flag  <= 1'b0;
    end else begin
      pulse <= evt && immediate;
      if (clear)                   flag <= 1'b0;
      else if (evt && !immediate)  flag <= 1'b1;
    end
  end

  // R9: a clear request always wins
  p_clear_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !flag);
  // R8: immediate mode does not raise the flag
  p_imm_no_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && immediate && !flag) |=> !flag);
  // R8: pulses only come from immediate mode
  p_pulse_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> $past(immediate));
endmodule

// File: rtl/irq_table_engine.sv
module irq_table_engine
  import tabling_pkg::*;
#(
  parameter int VEC_BASE = 150
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_act,
  input  logic              load_aux,
  input  logic [WORD_W-1:0] ptr_wdata,
  input  logic [CBR_W-1:0]  chain_base,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic              trig_valid,
  input  logic              trig_ext,
  input  logic [STAT_W-1:0] trig_status,
  input  logic [IDX_W-1:0]  trig_index,
  input  logic [WORD_W-1:0] trig_acw,
  output logic              trig_busy,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  output logic              full_irq,
  output logic [VEC_W-1:0]  full_vec,
  input  logic              act_immediate,
  output logic              act_pulse,
  output logic              act_flag,
  input  logic              act_clear
);
  typedef enum logic [1:0] {S_IDLE, S_HEAD, S_TAIL} st_t;

  st_t               state;
  evt_t              cur, pend, incoming;
  logic              pend_valid;
  logic [WORD_W-1:0] act_ptr;
  logic              swap;
  logic              entry_done;
  logic              head_accept;
  logic [ADDR_W-1:0] base_addr;

  assign incoming = '{ext: trig_ext, status: trig_status, index: trig_index, acw: trig_acw};
  assign trig_busy = pend_valid;

  always_comb begin
    base_addr   = entry_base(chain_base, act_ptr);
    mem_req     = (state != S_IDLE);
    mem_addr    = base_addr + ADDR_W'(state == S_TAIL);
    mem_wdata   = (state == S_TAIL) ? cur.acw : head_word(cur);
    head_accept = (state == S_HEAD) && mem_ack;
    entry_done  = (head_accept && !cur.ext) || ((state == S_TAIL) && mem_ack);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cur        <= '0;
      pend       <= '0;
      pend_valid <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (pend_valid) begin
            cur        <= pend;
            pend_valid <= 1'b0;
            state      <= S_HEAD;
          end else if (trig_valid) begin
            cur   <= incoming;
            state <= S_HEAD;
          end
        end
        S_HEAD: if (mem_ack) state <= cur.ext ? S_TAIL : S_IDLE;
        default: if (mem_ack) state <= S_IDLE;
      endcase
      if (state != S_IDLE && trig_valid && !pend_valid) begin
        pend       <= incoming;
        pend_valid <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_irq <= 1'b0;
      full_vec <= '0;
    end else begin
      full_irq <= swap;
      if (swap) full_vec <= full_vector(VEC_BASE, bank_sel);
    end
  end

  tab_ptr_regs u_ptr (
    .clk(clk), .rst_n(rst_n), .load_act(load_act), .load_aux(load_aux),
    .wdata(ptr_wdata), .adv(entry_done), .act_ptr(act_ptr), .swap(swap)
  );

  tab_activity u_act (
    .clk(clk), .rst_n(rst_n), .evt(entry_done), .immediate(act_immediate),
    .clear(act_clear), .pulse(act_pulse), .flag(act_flag)
  );

  // R11: a stalled request keeps its address and data
  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr) && $stable(mem_wdata));
  // R1: an idle, empty engine starts writing one cycle after an event
  p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_req && !trig_busy && trig_valid) |=> mem_req);
  // R6: the vector carries the bank offset
  p_full_vec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    full_irq |-> full_vec == VEC_W'(VEC_BASE) + VEC_W'($past(bank_sel)));
  // R10: a full pending slot blocks until it drains
  p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_busy && mem_req) |=> trig_busy);
endmodule

// File: tb/sim_irq_table_engine.sv
module sim_irq_table_engine;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        load_act, load_aux;
  logic [35:0] ptr_wdata;
  logic [14:0] chain_base;
  logic [8:0]  bank_sel;
  logic        trig_valid, trig_ext;
  logic [16:0] trig_status;
  logic [13:0] trig_index;
  logic [35:0] trig_acw;
  logic        trig_busy, mem_req, mem_ack;
  logic [23:0] mem_addr;
  logic [35:0] mem_wdata;
  logic        full_irq, act_immediate, act_pulse, act_flag, act_clear;
  logic [9:0]  full_vec;
  logic        stall, ack_ok;

  int n_chk = 0, n_bad = 0;
  int cyc = 0, n_log = 0, n_full = 0, n_pulse = 0;
  int last_wr_cyc = 0, full_cyc = 0;
  logic [23:0] log_addr [64];
  logic [35:0] log_data [64];
  logic [9:0]  last_vec;
  logic        held = 1'b0;
  logic [23:0] held_addr;
  logic [35:0] held_data;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign mem_ack = mem_req && ack_ok;

  irq_table_engine u0 (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req && mem_ack && n_log < 64) begin
      log_addr[n_log] <= mem_addr;
      log_data[n_log] <= mem_wdata;
      n_log <= n_log + 1;
      last_wr_cyc <= cyc;
    end
    if (full_irq) begin n_full <= n_full + 1; last_vec <= full_vec; full_cyc <= cyc; end
    if (act_pulse) n_pulse <= n_pulse + 1;
    if (held) begin
      chk("R11 req held", {63'b0, mem_req}, 64'd1);
      chk("R11 addr held", {40'b0, mem_addr}, {40'b0, held_addr});
      chk("R11 data held", {28'b0, mem_wdata}, {28'b0, held_data});
    end
    held <= mem_req && !mem_ack;
    held_addr <= mem_addr;
    held_data <= mem_wdata;
  end

  always @(negedge clk) ack_ok <= stall ? ~ack_ok : 1'b1;

  function automatic logic [35:0] exp_head(input logic e, input logic [16:0] s, input logic [13:0] ix);
    logic [35:0] w = 36'(ix);
    if (e) w = w | (36'(s) << 18) | (36'h1 << 35);
    return w;
  endfunction

  task automatic load_ptrs(input logic [17:0] acnt, input logic [17:0] aadr,
                           input logic do_aux, input logic [17:0] xcnt, input logic [17:0] xadr);
    @(negedge clk);
    load_act = 1'b1; ptr_wdata = {acnt, aadr};
    @(negedge clk);
    load_act = 1'b0;
    if (do_aux) begin
      load_aux = 1'b1; ptr_wdata = {xcnt, xadr};
      @(negedge clk);
      load_aux = 1'b0;
    end
  endtask

  task automatic fire(input logic e, input logic [16:0] s, input logic [13:0] ix, input logic [35:0] a);
    @(negedge clk);
    trig_valid = 1'b1; trig_ext = e; trig_status = s; trig_index = ix; trig_acw = a;
    @(negedge clk);
    trig_valid = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R12 mem_req", {63'b0, mem_req}, 0);
    chk("R12 busy", {63'b0, trig_busy}, 0);
    chk("R12 full_irq", {63'b0, full_irq}, 0);
    chk("R12 pulse/flag", {62'b0, act_pulse, act_flag}, 0);
  endtask

  task automatic t_external;
    int b = n_log;
    fire(1'b1, 17'h1ABCD, 14'h2345, 36'h987654321);
    chk("R1 R4 ext writes two words", 64'(n_log - b), 2);
    chk("R2 head addr", 64'(log_addr[b]), 64'(3 * 512 + 'h100));
    chk("R3 head word ext", 64'(log_data[b]), 64'(exp_head(1'b1, 17'h1ABCD, 14'h2345)));
    chk("R2 tail addr", 64'(log_addr[b+1]), 64'(3 * 512 + 'h101));
    chk("R4 tail acw", 64'(log_data[b+1]), 64'h987654321);
    chk("R8 sticky flag set", {63'b0, act_flag}, 1);
    chk("R8 no pulse sticky", 64'(n_pulse), 0);
    @(negedge clk); act_clear = 1'b1;
    @(negedge clk); act_clear = 1'b0;
    chk("R9 clear", {63'b0, act_flag}, 0);
  endtask

  task automatic t_monitor;
    int b = n_log;
    act_immediate = 1'b1;
    fire(1'b0, 17'h1FFFF, 14'h0042, 36'hFFFFFFFFF);
    chk("R4 monitor one word", 64'(n_log - b), 1);
    chk("R5 addr +2", 64'(log_addr[b]), 64'(3 * 512 + 'h102));
    chk("R3 monitor status zero", 64'(log_data[b]), 64'h42);
    chk("R8 pulse", 64'(n_pulse), 1);
    chk("R8 flag untouched", {63'b0, act_flag}, 0);
  endtask

  task automatic t_full_swap;
    int b = n_log;
    fire(1'b0, 17'h0, 14'h0007, 36'h0);
    chk("R5 third entry addr", 64'(log_addr[b]), 64'(3 * 512 + 'h104));
    chk("R6 full count", 64'(n_full), 1);
    chk("R6 vector", 64'(last_vec), 64'(150 + 5));
    chk("R6 full timing", 64'(full_cyc), 64'(last_wr_cyc + 1));
    fire(1'b0, 17'h0, 14'h0008, 36'h0);
    chk("R6 swapped addr", 64'(log_addr[b+1]), 64'(3 * 512 + 'h400));
    fire(1'b0, 17'h0, 14'h0009, 36'h0);
    chk("R6 second swap", 64'(n_full), 2);
    fire(1'b0, 17'h0, 14'h000A, 36'h0);
    chk("R7 aux reused", 64'(log_addr[b+3]), 64'(3 * 512 + 'h400));
  endtask

  task automatic t_pending;
    int b;
    load_ptrs(18'd100, 18'h200, 1'b0, 18'd0, 18'd0);
    b = n_log;
    stall = 1'b1;
    @(negedge clk);
    trig_valid = 1'b1; trig_ext = 1'b1; trig_status = 17'h00011; trig_index = 14'd1; trig_acw = 36'hA;
    @(negedge clk);
    trig_ext = 1'b0; trig_index = 14'd2;
    @(negedge clk);
    chk("R10 busy", {63'b0, trig_busy}, 1);
    trig_index = 14'd3;
    @(negedge clk);
    trig_valid = 1'b0;
    repeat (20) @(negedge clk);
    stall = 1'b0;
    chk("R10 three words", 64'(n_log - b), 3);
    chk("R10 first entry", 64'(log_addr[b]), 64'(3 * 512 + 'h200));
    chk("R10 pending tabled", 64'(log_data[b+2]), 64'h2);
    chk("R10 pending addr", 64'(log_addr[b+2]), 64'(3 * 512 + 'h202));
    chk("R10 busy released", {63'b0, trig_busy}, 0);
  endtask

  task automatic t_clear_priority;
    act_immediate = 1'b0;
    @(negedge clk); act_clear = 1'b1;
    fire(1'b0, 17'h0, 14'h0011, 36'h0);
    act_clear = 1'b0;
    @(negedge clk);
    chk("R9 clear beats set", {63'b0, act_flag}, 0);
    fire(1'b0, 17'h0, 14'h0012, 36'h0);
    chk("R8 sticky again", {63'b0, act_flag}, 1);
  endtask

  initial begin
    rst_n = 1'b0; load_act = 0; load_aux = 0; ptr_wdata = '0;
    chain_base = 15'd3; bank_sel = 9'd5;
    trig_valid = 0; trig_ext = 0; trig_status = '0; trig_index = '0; trig_acw = '0;
    act_immediate = 1'b0; act_clear = 1'b0; stall = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    load_ptrs(18'd6, 18'h100, 1'b1, 18'd4, 18'h400);
    t_external();
    t_monitor();
    t_full_swap();
    t_pending();
    t_clear_priority();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule